// File: doc/BRIEF.md
# PHY Power-Up Initialization Sequencer

This block brings a host-side PHY out of power-up with no software involved. When reset is released it starts at once and works through a fixed list of accesses to 8-bit PHY registers over a simple request/acknowledge register port. Most steps read a register, OR in a fixed mask and write the result back to the same address. The final step is a plain write that selects the default-speed bus mode.

Between the pad setup steps and the line setup steps, the block waits for the pad calibration to finish. It does this by reading the calibration status register back-to-back until the done bit is set. This wait is bounded by a cycle budget. The budget is derived from the clock frequency in MHz and a timeout in microseconds. If the budget runs out, or if any access reports a failure, the sequence stops with the error flag set. Otherwise it ends with the done flag set.

Both flags hold their value until reset or until a `start` pulse runs the sequence again.

Top module: `phy_init_seq`

## Requirements
- R1: After reset is released, and after a `start` pulse while the block is idle, the first access is a read (`acc_wr`=0) of address 0x01. `done` and `error` are both 0 while the sequence runs.
- R2: Pad setup is done as read-modify-write. Address 0x01 is written with its read value OR 0x42. Then address 0x02 is written with its read value OR 0x02. Each write directly follows the read of the same address.
- R3: After the pad setup, address 0x03 is read repeatedly with no other access in between. The sequence moves on only after a read returns bit 4 (0x10) set. No line setup access happens before that read.
- R4: The calibration wait has a budget of LIMIT = CLK_MHZ*TIMEOUT_US cycles. If a status read completes with bit 4 clear after LIMIT cycles have passed in the wait, the block sets `error` and issues no further access. The error comes no earlier than LIMIT cycles after the first status request.
- R5: Line setup is done as read-modify-write, in this order, with these OR masks: 0x06|0x03, 0x08|0x02, 0x20|0x01, 0x07|0xFF, 0x09|0xFF, 0x21|0xFF, 0x22|0x01, 0x23|0x01, 0x0F|0x07.
- R6: The last access is a write of 0x04 to address 0x11 with no read before it. `done` rises right after that write is acknowledged.
- R7: If an acknowledged access has `acc_err`=1, at any step, the block sets `error` and issues no further access.
- R8: `done` and `error` are never both 1. Each one holds until reset or a `start` pulse, and a `start` pulse clears both.
- R9: A `start` pulse while a sequence is running has no effect on the accesses that are issued.
- R10: While `acc_req` is 1 and `acc_ack` is 0, the request stays asserted and `acc_addr`, `acc_wr` and `acc_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: rerun the sequence when idle |
| acc_req | output | 1 | Register access request, held until acknowledged |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_addr | output | AW | PHY register address |
| acc_wdata | output | DW | Write data |
| acc_ack | input | 1 | Access complete (one cycle) |
| acc_err | input | 1 | Access failed; valid together with acc_ack |
| acc_rdata | input | DW | Read data; valid together with acc_ack |
| done | output | 1 | Sequence finished without error (sticky) |
| error | output | 1 | Sequence aborted (sticky) |

## Verification
The next access is presented in the cycle after the acknowledge edge. `done` and `error` change at the same edge that samples the acknowledge of the last access, so the bench waits for a flag at falling edges and only then compares the whole logged access trace. The timeout result is due one status read after LIMIT cycles in the wait. The bench therefore checks that the error arrives in a window of LIMIT to LIMIT plus one access latency plus a few cycles, measured from the first status request. Each check of an ignored input or an abort is followed by a few idle cycles, to confirm that no extra access appears.

// File: rtl/phy_init_seq.sv
module phy_init_seq #(
  parameter int CLK_MHZ    = 200,
  parameter int TIMEOUT_US = 100,
  parameter int AW         = 8,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          acc_req,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  input  logic          acc_ack,
  input  logic          acc_err,
  input  logic [DW-1:0] acc_rdata,
  output logic          done,
  output logic          error
);
  localparam int LIMIT    = CLK_MHZ * TIMEOUT_US;
  localparam int TW       = $clog2(LIMIT + 1);
  localparam int SW       = 4;
  localparam int CAL_STEP = 2;

  localparam logic [1:0] K_RMW  = 2'd0;
  localparam logic [1:0] K_POLL = 2'd1;
  localparam logic [1:0] K_WR   = 2'd2;

  logic          run;
  logic [SW-1:0] step;
  logic          wphase;
  logic [DW-1:0] hold;
  logic [TW-1:0] tmr;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_mask;
  logic [1:0]    s_kind;

  always_comb begin
    s_kind = K_RMW;
    s_addr = '0;
    s_mask = '0;
    case (step)
      4'd0:    begin s_addr = AW'(8'h01); s_mask = DW'(8'h42); end
      4'd1:    begin s_addr = AW'(8'h02); s_mask = DW'(8'h02); end
      4'd2:    begin s_addr = AW'(8'h03); s_mask = DW'(8'h10); s_kind = K_POLL; end
      4'd3:    begin s_addr = AW'(8'h06); s_mask = DW'(8'h03); end
      4'd4:    begin s_addr = AW'(8'h08); s_mask = DW'(8'h02); end
      4'd5:    begin s_addr = AW'(8'h20); s_mask = DW'(8'h01); end
      4'd6:    begin s_addr = AW'(8'h07); s_mask = DW'(8'hFF); end
      4'd7:    begin s_addr = AW'(8'h09); s_mask = DW'(8'hFF); end
      4'd8:    begin s_addr = AW'(8'h21); s_mask = DW'(8'hFF); end
      4'd9:    begin s_addr = AW'(8'h22); s_mask = DW'(8'h01); end
      4'd10:   begin s_addr = AW'(8'h23); s_mask = DW'(8'h01); end
      4'd11:   begin s_addr = AW'(8'h0F); s_mask = DW'(8'h07); end
      default: begin s_addr = AW'(8'h11); s_mask = DW'(8'h04); s_kind = K_WR; end
    endcase
  end

  assign acc_req   = run;
  assign acc_wr    = (s_kind == K_WR) | ((s_kind == K_RMW) & wphase);
  assign acc_addr  = s_addr;
  assign acc_wdata = (s_kind == K_WR) ? s_mask : (hold | s_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b1;
      step   <= '0;
      wphase <= 1'b0;
      hold   <= '0;
      tmr    <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else if (!run) begin
      if (start) begin
        run    <= 1'b1;
        step   <= '0;
        wphase <= 1'b0;
        tmr    <= '0;
        done   <= 1'b0;
        error  <= 1'b0;
      end
    end else begin
      if (step == SW'(CAL_STEP) && tmr != TW'(LIMIT)) tmr <= tmr + 1'b1;
      if (acc_ack) begin
        if (acc_err) begin
          run   <= 1'b0;
          error <= 1'b1;
        end else begin
          case (s_kind)
            K_RMW: begin
              if (!wphase) begin
                hold   <= acc_rdata;
                wphase <= 1'b1;
              end else begin
                wphase <= 1'b0;
                step   <= step + 1'b1;
              end
            end
            K_POLL: begin
              if (|(acc_rdata & s_mask)) step <= step + 1'b1;
              else if (tmr == TW'(LIMIT)) begin
                run   <= 1'b0;
                error <= 1'b1;
              end
            end
            default: begin
              run  <= 1'b0;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          acc_req,
  input logic          acc_wr,
  input logic [AW-1:0] acc_addr,
  input logic [DW-1:0] acc_wdata,
  input logic          acc_ack,
  input logic          acc_err,
  input logic          done,
  input logic          error
);
  assert_restart_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !acc_req |=> acc_req && !acc_wr && acc_addr == AW'(8'h01));

  assert_stop_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_ack && acc_err |=> error && !acc_req);

  assert_quiet_when_finished_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) && !start |=> !acc_req);

  assert_final_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(acc_req && acc_ack && acc_wr && acc_addr == AW'(8'h11) && acc_wdata == DW'(8'h04)));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) && !start |=> $stable(done) && $stable(error));

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_wr) && $stable(acc_wdata));
endmodule

bind phy_init_seq phy_init_seq_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/phy_init_seq_tb_top.sv
module phy_init_seq_tb_top;
  localparam int CLK_MHZ = 200;
  localparam int TOUT_US = 2;
  localparam int LIMIT   = CLK_MHZ * TOUT_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic acc_req, acc_wr, acc_ack, acc_err, done, error;
  logic [7:0] acc_addr, acc_wdata, acc_rdata;

  always #2.5 clk = ~clk;

  phy_init_seq #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TOUT_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata),
    .done(done), .error(error));

  // PHY register model
  logic load = 1'b1;
  int seed = 0, lat = 0, cal_after = 0, fail_at = -1;
  int nops, npolls, cnt, unstable;
  logic [7:0] regs [64];
  logic       log_wr [64];
  logic [7:0] log_addr [64];
  logic [7:0] log_data [64];
  logic [7:0] prev_addr, rv;

  function automatic logic [7:0] init_val(int s, int a);
    return 8'((a * 29) ^ s);
  endfunction

  always @(posedge clk) begin
    if (load || !rst_n) begin
      for (int a = 0; a < 64; a++) regs[a] <= init_val(seed, a);
      acc_ack <= 1'b0; acc_err <= 1'b0; acc_rdata <= 8'h00;
      nops <= 0; npolls <= 0; cnt <= 0; unstable <= 0;
    end else if (acc_ack) begin
      acc_ack <= 1'b0; acc_err <= 1'b0;
    end else if (acc_req) begin
      if (cnt > 0 && acc_addr != prev_addr) unstable <= unstable + 1;
      prev_addr <= acc_addr;
      if (cnt < lat) cnt <= cnt + 1;
      else begin
        cnt <= 0;
        acc_ack <= 1'b1;
        acc_err <= (nops == fail_at);
        rv = regs[acc_addr[5:0]];
        if (acc_addr == 8'h03 && !acc_wr) begin
          if (npolls >= cal_after) rv = rv | 8'h10;
          else rv = rv & 8'hEF;
          npolls <= npolls + 1;
        end
        acc_rdata <= rv;
        if (nops < 64) begin
          log_wr[nops] <= acc_wr;
          log_addr[nops] <= acc_addr;
          log_data[nops] <= acc_wr ? acc_wdata : rv;
        end
        nops <= nops + 1;
        if (acc_wr && nops != fail_at) regs[acc_addr[5:0]] <= acc_wdata;
      end
    end
  end

  // Bench bookkeeping
  int nchk = 0, nfail = 0;
  int e_n;
  logic       e_wr [64];
  logic [7:0] e_addr [64];
  logic [7:0] e_data [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic [7:0] a, input logic [7:0] d);
    e_wr[e_n] = w; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
  endtask

  task automatic rmw(input logic [7:0] a, input logic [7:0] m);
    push(1'b0, a, init_val(seed, int'(a)));
    push(1'b1, a, init_val(seed, int'(a)) | m);
  endtask

  task automatic build_expected();
    e_n = 0;
    rmw(8'h01, 8'h42);                    // R2
    rmw(8'h02, 8'h02);                    // R2
    for (int p = 0; p <= cal_after; p++)  // R3
      push(1'b0, 8'h03, (p >= cal_after) ? (init_val(seed, 3) | 8'h10) : (init_val(seed, 3) & 8'hEF));
    rmw(8'h06, 8'h03); rmw(8'h08, 8'h02); rmw(8'h20, 8'h01);   // R5
    rmw(8'h07, 8'hFF); rmw(8'h09, 8'hFF); rmw(8'h21, 8'hFF);
    rmw(8'h22, 8'h01); rmw(8'h23, 8'h01); rmw(8'h0F, 8'h07);
    push(1'b1, 8'h11, 8'h04);             // R6
  endtask

  task automatic wait_end(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || error) begin ok = 1'b1; break; end
    end
    if (!ok) chk(1'b0, "R1 watchdog", 0, 1);
  endtask

  task automatic compare_trace(input int upto, input string req);
    int bad = 0;
    for (int i = 0; i < upto; i++)
      if (log_wr[i] !== e_wr[i] || log_addr[i] !== e_addr[i] || log_data[i] !== e_data[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic arm(input int s, input int l, input int c, input int f);
    @(negedge clk);
    seed = s; lat = l; cal_after = c; fail_at = f; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    bit ok;
    int t0, t1, saved;
    // reset state and automatic run after reset (R1)
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && error == 1'b0, "R1 flags in reset", {done, error}, 0);
    load = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_req && !acc_wr && acc_addr == 8'h01, "R1 first access", acc_addr, 8'h01);
    chk(done == 1'b0 && error == 1'b0, "R1 flags while running", {done, error}, 0);
    build_expected();
    wait_end(ok);
    chk(done && !error, "R6 done after reset run", {done, error}, 2);
    chk(nops == e_n, "R5 access count", nops, e_n);
    compare_trace(e_n, "R2 R3 R5 R6 trace after reset");

    // sweep: patterns x latency x calibration delay
    for (int s = 0; s < 3; s++)
      for (int l = 0; l < 4; l++)
        for (int c = 0; c < 3; c++) begin
          arm((s == 0) ? 0 : (s == 1) ? 8'h5A : 8'hFF, l, c * c + c, -1);
          pulse_start();
          chk(acc_req && !acc_wr && acc_addr == 8'h01, "R1 restart first access", acc_addr, 8'h01);
          chk(!done && !error, "R8 start clears flags", {done, error}, 0);
          build_expected();
          wait_end(ok);
          chk(done && !error, "R6 done", {done, error}, 2);
          chk(nops == e_n, "R3 access count", nops, e_n);
          compare_trace(e_n, "R2 R3 R5 trace");
          chk(regs[6'h11] == 8'h04, "R6 mode write", regs[6'h11], 8'h04);
          chk(unstable == 0, "R10 request stable", unstable, 0);
        end

    // sticky done, no further accesses (R8)
    saved = nops;
    repeat (30) @(negedge clk);
    chk(done && !error, "R8 done sticky", {done, error}, 2);
    chk(nops == saved && !acc_req, "R8 no access after done", nops, saved);

    // access failure at every position (R7)
    for (int k = 0; k < 24; k++) begin
      arm(8'h33, k % 3, 0, k);
      pulse_start();
      wait_end(ok);
      repeat (10) @(negedge clk);
      chk(error && !done, "R7 error flag", {done, error}, 1);
      chk(nops == k + 1, "R7 stop after failed access", nops, k + 1);
    end

    // calibration timeout (R4)
    arm(8'h11, 1, 100000, -1);
    pulse_start();
    t0 = -1; t1 = -1;
    for (int i = 0; i < 3000; i++) begin
      if (t0 < 0 && acc_req && acc_addr == 8'h03) t0 = i;
      if (error) begin t1 = i; break; end
      @(negedge clk);
    end
    chk(t1 >= 0 && error && !done, "R4 timeout error", {done, error}, 1);
    chk(t1 - t0 >= LIMIT && t1 - t0 <= LIMIT + 6, "R4 timeout window", t1 - t0, LIMIT);
    saved = nops;
    repeat (10) @(negedge clk);
    chk(nops == saved && log_addr[nops - 1] == 8'h03, "R4 no line setup after timeout", log_addr[nops - 1], 8'h03);
    chk(!done && error, "R8 error sticky", {done, error}, 1);

    // start while running is ignored (R9)
    arm(8'hC3, 2, 3, -1);
    pulse_start();
    repeat (17) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    build_expected();
    wait_end(ok);
    chk(done && !error, "R9 done", {done, error}, 2);
    chk(nops == e_n, "R9 access count", nops, e_n);
    compare_trace(e_n, "R9 trace unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule